// File: doc/BRIEF.md
# Twelve-Pin GPIO Controller with Level-Latched Interrupts

This block is a register-mapped general-purpose I/O controller for twelve pins. Software drives output levels through a data register and decides which pins actually drive through an enable register. Every pin level goes through a two-flop synchronizer. The synchronized levels can be read back at any time, whatever the output-enable setting.

Each pin can raise a level-sensitive interrupt, and software picks active-high or active-low sensing per pin. The polarity bits are packed into two type registers at every fourth bit position. When a pin sits at its active level, its status bit latches. The bit holds until software writes a one to it. If the pin is still active when the bit is cleared, the bit sets again on the next cycle. One interrupt output combines all status bits that the enable register leaves unmasked. A 32-bit mux control word is stored and driven out unchanged for neighbouring pad logic.

The register port is a plain synchronous bus with byte addresses. A write takes effect on the clock edge where `csr_we` is high. Read data is combinational from the current address. The register port, pins and interrupt are control signals with no handshake: a write cannot be stalled and a read needs no request.

Top module: `gpio_lvl_ctrl`

## Requirements
- R1: After reset every register reads zero, `pin_oe`, `pin_out` and `mux_sel` are zero, and `irq_out` is low.
- R2: The output-enable register is at byte offset 0x04 and the output data register at 0x00. `pin_oe` equals the enable register, and `pin_out` carries the data bit only where the enable bit is 1 (0 elsewhere).
- R3: Offset 0x08 returns the pin levels after a two-flop synchronizer. A level applied before clock edge k can be read after edge k+1, whatever `pin_oe` is.
- R4: Pin n has its polarity bit at bit 4*(n mod 8), in the register at 0x10 for n < 8 and in the register at 0x18 for n >= 8. A bit value of 0 means active-high and 1 means active-low.
- R5: Status bit n (offset 0x0C) sets once the synchronized level of pin n is active. It stays set regardless of the enable mask. Writing 1 to the bit clears it, and writing 0 leaves it unchanged.
- R6: If a status bit is cleared while its pin is still active, it reads 0 after the write edge and 1 again after the following edge.
- R7: `irq_out` is high exactly when status AND enable (offset 0x14, 1 = unmasked) is non-zero.
- R8: Offset 0x1C holds a 32-bit read/write mux word, and `mux_sel` always equals it.
- R9: Bits 12 to 31 of the per-pin registers read as zero and ignore writes. The type registers keep only the polarity positions. Offset 0x08 ignores writes, and offsets 0x20 and above read zero and ignore writes.
- R10: `csr_rdata` reflects the register addressed by `csr_addr` in the same cycle, with no read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_we | input | 1 | Write strobe |
| csr_addr | input | 6 | Byte address, bits 1:0 ignored |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data for `csr_addr` |
| pin_in | input | 12 | Asynchronous pin levels |
| pin_out | output | 12 | Output levels, gated by enable |
| pin_oe | output | 12 | Per-pin output enable |
| irq_out | output | 1 | Combined interrupt |
| mux_sel | output | 32 | Stored mux control word |

## Verification
The bench targets the case where a status bit is cleared while its pin is still active. A design that lets the set term win would never show the zero cycle, and one that forgets the live level would never re-arm. It also checks the polarity bit positions across both type registers: a design that packs them densely or puts pins 8 to 11 in the wrong register would latch the wrong pins. It checks the synchronizer delay, where one stage too many or too few moves the input read by a cycle, and masked pins, which must still latch but must not raise `irq_out`. Unused bits, the read-only input register and unmapped addresses are written with ones, so any stray storage shows up on readback.

// File: rtl/gpio_lvl_pkg.sv
package gpio_lvl_pkg;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 32;
  localparam int NPIN   = 12;
  localparam int IDX_W  = ADDR_W - 2;
  typedef logic [IDX_W-1:0] widx_t;

  // word indices (byte offset / 4)
  localparam widx_t W_DOUT = widx_t'(0);
  localparam widx_t W_OE   = widx_t'(1);
  localparam widx_t W_LVL  = widx_t'(2);
  localparam widx_t W_STAT = widx_t'(3);
  localparam widx_t W_TYPA = widx_t'(4);
  localparam widx_t W_EN   = widx_t'(5);
  localparam widx_t W_TYPB = widx_t'(6);
  localparam widx_t W_MUX  = widx_t'(7);

  localparam int PINS_PER_TYPE = 8;
  localparam int TYPE_STRIDE   = 4;
endpackage

// File: rtl/gpio_lvl_sync.sv
module gpio_lvl_sync #(
  parameter int W      = 12,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] chain_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rst_n) chain_q[s] <= '0;
        else if (s == 0) chain_q[s] <= d_async;
        else chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign d_sync = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_lvl_irq.sv
module gpio_lvl_irq #(
  parameter int NPIN = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] lvl,
  input  logic [NPIN-1:0] pol,
  input  logic [NPIN-1:0] en,
  input  logic [NPIN-1:0] clr,
  output logic [NPIN-1:0] status,
  output logic            irq
);
  logic [NPIN-1:0] active;
  logic [NPIN-1:0] status_d;

  // pol 0: high is active, pol 1: low is active
  assign active = lvl ^ pol;

  // the clear wins in its own cycle so an acknowledge is visible for one cycle
  always_comb begin
    status_d = (status | active) & ~clr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) status <= '0;
    else        status <= status_d;
  end

  assign irq = |(status & en);
endmodule

// File: rtl/gpio_lvl_regs.sv
module gpio_lvl_regs
  import gpio_lvl_pkg::*;
#(
  parameter int NPIN = 12,
  parameter int DW   = 32,
  parameter int AW   = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  input  logic [NPIN-1:0] lvl,
  input  logic [NPIN-1:0] status,
  output logic [NPIN-1:0] dout,
  output logic [NPIN-1:0] oe,
  output logic [NPIN-1:0] pol,
  output logic [NPIN-1:0] en,
  output logic [NPIN-1:0] clr,
  output logic [DW-1:0]   mux,
  output logic [DW-1:0]   rdata
);
  localparam int PAD = DW - NPIN;

  widx_t           widx;
  logic            in_map;
  logic [NPIN-1:0] pol_d;
  logic [DW-1:0]   typa_rd, typb_rd;

  assign widx   = addr[AW-1:2];
  assign in_map = (addr[AW-1:2] <= W_MUX);

  // polarity write: pin n takes bit 4*(n mod 8) of its type register
  always_comb begin
    pol_d = pol;
    if (we && in_map) begin
      for (int n = 0; n < NPIN; n++) begin
        if (widx == ((n < PINS_PER_TYPE) ? W_TYPA : W_TYPB))
          pol_d[n] = wdata[TYPE_STRIDE*(n % PINS_PER_TYPE)];
      end
    end
  end

  always_comb begin
    typa_rd = '0;
    typb_rd = '0;
    for (int n = 0; n < NPIN; n++) begin
      if (n < PINS_PER_TYPE) typa_rd[TYPE_STRIDE*n] = pol[n];
      else                   typb_rd[TYPE_STRIDE*(n % PINS_PER_TYPE)] = pol[n];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout <= '0;
      oe   <= '0;
      en   <= '0;
      mux  <= '0;
      pol  <= '0;
    end else begin
      pol <= pol_d;
      if (we && in_map) begin
        case (widx)
          W_DOUT:  dout <= wdata[NPIN-1:0];
          W_OE:    oe   <= wdata[NPIN-1:0];
          W_EN:    en   <= wdata[NPIN-1:0];
          W_MUX:   mux  <= wdata;
          default: ;
        endcase
      end
    end
  end

  assign clr = (we && in_map && widx == W_STAT) ? wdata[NPIN-1:0] : '0;

  always_comb begin
    rdata = '0;
    if (in_map) begin
      case (widx)
        W_DOUT:  rdata = {{PAD{1'b0}}, dout};
        W_OE:    rdata = {{PAD{1'b0}}, oe};
        W_LVL:   rdata = {{PAD{1'b0}}, lvl};
        W_STAT:  rdata = {{PAD{1'b0}}, status};
        W_TYPA:  rdata = typa_rd;
        W_EN:    rdata = {{PAD{1'b0}}, en};
        W_TYPB:  rdata = typb_rd;
        W_MUX:   rdata = mux;
        default: rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_lvl_ctrl.sv
module gpio_lvl_ctrl
  import gpio_lvl_pkg::*;
#(
  parameter int NPIN     = gpio_lvl_pkg::NPIN,
  parameter int DW       = DATA_W,
  parameter int AW       = ADDR_W,
  parameter int SYNC_STG = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            csr_we,
  input  logic [AW-1:0]   csr_addr,
  input  logic [DW-1:0]   csr_wdata,
  output logic [DW-1:0]   csr_rdata,
  input  logic [NPIN-1:0] pin_in,
  output logic [NPIN-1:0] pin_out,
  output logic [NPIN-1:0] pin_oe,
  output logic            irq_out,
  output logic [DW-1:0]   mux_sel
);
  logic [NPIN-1:0] lvl_w, dout_w, oe_w, pol_w, en_w, clr_w, stat_w;

  gpio_lvl_sync #(.W(NPIN), .STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(pin_in), .d_sync(lvl_w)
  );

  gpio_lvl_regs #(.NPIN(NPIN), .DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(csr_we), .addr(csr_addr), .wdata(csr_wdata),
    .lvl(lvl_w), .status(stat_w), .dout(dout_w), .oe(oe_w), .pol(pol_w),
    .en(en_w), .clr(clr_w), .mux(mux_sel), .rdata(csr_rdata)
  );

  gpio_lvl_irq #(.NPIN(NPIN)) u_irq (
    .clk(clk), .rst_n(rst_n), .lvl(lvl_w), .pol(pol_w), .en(en_w),
    .clr(clr_w), .status(stat_w), .irq(irq_out)
  );

  assign pin_oe  = oe_w;
  assign pin_out = dout_w & oe_w;
endmodule

// File: rtl/gpio_lvl_ctrl_chk.sv
module gpio_lvl_ctrl_chk #(
  parameter int NPIN = 12,
  parameter int DW   = 32,
  parameter int AW   = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            csr_we,
  input logic [AW-1:0]   csr_addr,
  input logic [DW-1:0]   csr_wdata,
  input logic [DW-1:0]   csr_rdata,
  input logic            irq_out,
  input logic [DW-1:0]   mux_sel,
  input logic [NPIN-1:0] stat,
  input logic [NPIN-1:0] en
);
  logic stat_wr, mux_wr, narrow_rd;
  assign stat_wr   = csr_we && (csr_addr[AW-1:2] == 3);
  assign mux_wr    = csr_we && (csr_addr[AW-1:2] == 7);
  assign narrow_rd = (csr_addr[AW-1:2] <= 3) || (csr_addr[AW-1:2] == 5);

  a_r7_irq_matches_mask: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == |(stat & en));

  a_r5_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_wr |=> (($past(stat) & ~stat) == '0));

  a_r6_clear_visible: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr |=> ((stat & $past(csr_wdata[NPIN-1:0])) == '0));

  a_r8_mux_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    mux_wr |=> (mux_sel == $past(csr_wdata)));

  a_r9_upper_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    narrow_rd |-> (csr_rdata[DW-1:NPIN] == '0));
endmodule

bind gpio_lvl_ctrl gpio_lvl_ctrl_chk #(.NPIN(NPIN), .DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
  .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .irq_out(irq_out),
  .mux_sel(mux_sel), .stat(stat_w), .en(en_w)
);

// File: tb/gpio_lvl_ctrl_test.sv
`timescale 1ns/1ps
module gpio_lvl_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_we = 1'b0;
  logic [5:0]  csr_addr = '0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic [11:0] pin_in = '0;
  logic [11:0] pin_out, pin_oe;
  logic        irq_out;
  logic [31:0] mux_sel;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  gpio_lvl_ctrl uut (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out), .mux_sel(mux_sel)
  );

  // reference state built from the requirements
  logic [11:0] m_dout, m_oe, m_pol, m_en, m_stat, m_s1, m_s2;
  logic [31:0] m_mux;

  always @(posedge clk) begin
    logic [11:0] clr, act, pol_n;
    if (!rst_n) begin
      m_dout <= '0; m_oe <= '0; m_pol <= '0; m_en <= '0;
      m_stat <= '0; m_s1 <= '0; m_s2 <= '0; m_mux <= '0;
    end else begin
      clr   = (csr_we && csr_addr[5:2] == 4'd3) ? csr_wdata[11:0] : 12'h0;
      act   = m_s2 ^ m_pol;
      pol_n = m_pol;
      m_s1  <= pin_in;
      m_s2  <= m_s1;
      m_stat <= (m_stat | act) & ~clr;
      if (csr_we) begin
        case (csr_addr[5:2])
          4'd0: m_dout <= csr_wdata[11:0];
          4'd1: m_oe   <= csr_wdata[11:0];
          4'd5: m_en   <= csr_wdata[11:0];
          4'd7: m_mux  <= csr_wdata;
          4'd4: for (int n = 0; n < 8; n++) pol_n[n] = csr_wdata[4*n];
          4'd6: for (int n = 8; n < 12; n++) pol_n[n] = csr_wdata[4*(n-8)];
          default: ;
        endcase
      end
      m_pol <= pol_n;
    end
  end

  function automatic logic [31:0] exp_rd(logic [5:0] a);
    logic [31:0] r = '0;
    case (a[5:2])
      4'd0: r = {20'h0, m_dout};
      4'd1: r = {20'h0, m_oe};
      4'd2: r = {20'h0, m_s2};
      4'd3: r = {20'h0, m_stat};
      4'd4: for (int n = 0; n < 8; n++) r[4*n] = m_pol[n];
      4'd5: r = {20'h0, m_en};
      4'd6: for (int n = 8; n < 12; n++) r[4*(n-8)] = m_pol[n];
      4'd7: r = m_mux;
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called just after a falling edge; returns just after the next one
  task automatic wr(logic [5:0] a, logic [31:0] d);
    csr_we = 1'b1; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic rd_chk(string tag, logic [5:0] a, logic [31:0] exp);
    csr_addr = a;
    #1;
    chk(tag, csr_rdata, exp);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    for (int a = 0; a < 8; a++) rd_chk("R1 reset read", 6'(a*4), 32'h0);
    chk("R1 pin_oe", {20'h0, pin_oe}, 32'h0);
    chk("R1 irq", {31'h0, irq_out}, 32'h0);
    chk("R1 mux_sel", mux_sel, 32'h0);

    // R2 output gating
    wr(6'h00, 32'hFFFF_FFFF);
    #1 chk("R2 pin_out with oe=0", {20'h0, pin_out}, 32'h0);
    wr(6'h04, 32'h0000_0F0F);
    #1 chk("R2 pin_oe", {20'h0, pin_oe}, 32'h0F0F);
    chk("R2 pin_out gated", {20'h0, pin_out}, 32'h0F0F);
    rd_chk("R9 data upper bits", 6'h00, 32'h0000_0FFF);

    // R3 synchronizer delay, independent of output enable
    pin_in = 12'hA5C;
    idle(1);
    rd_chk("R3 one edge later", 6'h08, 32'h0);
    idle(1);
    rd_chk("R3 two edges later", 6'h08, 32'hA5C);

    // R5 latching without enable, R7 masking
    idle(1);
    rd_chk("R5 status latched while masked", 6'h0C, 32'hA5C);
    #1 chk("R7 masked irq low", {31'h0, irq_out}, 32'h0);
    wr(6'h14, 32'h0000_0004);
    #1 chk("R7 unmasked irq high", {31'h0, irq_out}, 32'h1);
    pin_in = 12'h000;
    idle(3);
    rd_chk("R5 sticky after pins drop", 6'h0C, 32'hA5C);
    wr(6'h0C, 32'h0);
    rd_chk("R5 write zero keeps status", 6'h0C, 32'hA5C);
    wr(6'h0C, 32'h0000_000C);
    rd_chk("R5 write one clears", 6'h0C, 32'hA50);
    #1 chk("R7 irq drops after clear", {31'h0, irq_out}, 32'h0);

    // R6 clear while still active
    pin_in = 12'h001;
    idle(3);
    rd_chk("R6 pre", 6'h0C, 32'hA51);
    wr(6'h0C, 32'h0000_0001);
    rd_chk("R6 zero after clear", 6'h0C, 32'hA50);
    idle(1);
    rd_chk("R6 set again", 6'h0C, 32'hA51);

    // R4 polarity positions
    pin_in = 12'h000;
    idle(3);
    wr(6'h0C, 32'h0000_0FFF);
    rd_chk("R4 status cleared", 6'h0C, 32'h0);
    wr(6'h10, 32'h0000_1002);
    wr(6'h18, 32'hFFFF_0010);
    idle(2);
    rd_chk("R4 active-low pins 3 and 9", 6'h0C, 32'h0000_0208);
    rd_chk("R9 type A keeps positions only", 6'h10, 32'h0000_1000);
    rd_chk("R4 type B readback", 6'h18, 32'h0000_0010);

    // R8 mux word
    wr(6'h1C, 32'hDEAD_BEEF);
    #1 chk("R8 mux_sel", mux_sel, 32'hDEAD_BEEF);
    rd_chk("R8 mux readback", 6'h1C, 32'hDEAD_BEEF);

    // R9 unmapped and read-only
    wr(6'h24, 32'hFFFF_FFFF);
    rd_chk("R9 unmapped reads zero", 6'h24, 32'h0);
    wr(6'h08, 32'hFFFF_FFFF);
    rd_chk("R9 input register ignores write", 6'h08, 32'h0);

    // random phase, R10 same-cycle read against the reference state
    for (int i = 0; i < 4000; i++) begin
      csr_we    = ($urandom_range(0, 9) < 3);
      csr_addr  = 6'($urandom_range(0, 9) * 4);
      csr_wdata = $urandom();
      if ($urandom_range(0, 4) == 0) pin_in = 12'($urandom());
      #1;
      chk("R10 random read", csr_rdata, exp_rd(csr_addr));
      chk("R7 random irq", {31'h0, irq_out}, {31'h0, |(m_stat & m_en)});
      chk("R2 random pin_out", {20'h0, pin_out}, {20'h0, m_dout & m_oe});
      chk("R8 random mux", mux_sel, m_mux);
      @(negedge clk);
    end
    csr_we = 1'b0;
    finish_run();
  end
endmodule